// File: doc/BRIEF.md
# Radix-8 Booth Partial-Product Generator

This block turns a signed multiplier and a signed multiplicand, both N bits in two's complement, into the partial-product rows of a radix-8 Booth multiplication. The multiplier is split into overlapping windows of four bits, stepping three bits at a time. Each window becomes one signed digit in the range -4 to +4. Each digit selects a multiple of the multiplicand Y. The multiple is 0, Y, 2Y, 3Y or 4Y, and it is inverted when the digit is negative.

The odd multiple 3Y cannot be produced by wiring alone. One adder forms it as Y plus Y shifted left by one, once per operation, and every row shares that result. The block does not add the +1 that completes each negation. It reports one negation flag per row, and the downstream accumulator adds the flag at the row's least significant bit. Row j carries weight 8^j.

Operands are sampled on a clock edge where `in_valid` is high. The rows, the flags and `pp_valid` appear from the register stage one cycle later. They hold while `in_valid` is low.

Top module: `booth_r8_ppgen`

## Requirements
- R1: There are ROWS = ceil(N/3) rows. The digit of row j is -4·b(3j+2) + 2·b(3j+1) + b(3j) + b(3j-1), where b(-1) = 0 and bits above N-1 repeat the multiplier's sign bit. Over a varied operand set, all nine digit values -4 to +4 occur.
- R2: Row j occupies `pp_rows[j*W +: W]`, with W = N+3. For a digit d ≥ 0, the row holds d·Y in W-bit two's complement. For d < 0, it holds the bitwise inverse of |d|·Y.
- R3: `pp_neg[j]` is 1 exactly when the digit of row j is negative. A zero digit, from window 0000 or 1111, gives an all-zero row with flag 0.
- R4: Digits of magnitude 3 select 3Y, formed by one shared adder as Y + 2Y.
- R5: Digits of magnitude 2 and 4 select Y shifted left by one and by two places.
- R6: The sum over j of (signed row j + `pp_neg[j]`)·8^j equals the signed product of `mplier` and `mcand`.
- R7: A rising edge with `in_valid` = 1 loads new rows and flags, and `pp_valid` is 1 after that edge. A rising edge with `in_valid` = 0 drives `pp_valid` to 0.
- R8: While `in_valid` is 0, `pp_rows` and `pp_neg` keep their values, even when the operands change.
- R9: While reset is applied, `pp_rows` and `pp_neg` are all zero and `pp_valid` is 0. Reset acts asynchronously and is released through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe and register clock enable |
| mplier | input | N | Signed multiplier, recoded into digits |
| mcand | input | N | Signed multiplicand Y |
| pp_valid | output | 1 | Rows loaded on the previous edge |
| pp_rows | output | ROWS*W | Partial-product rows, row j at bits [j*W +: W] |
| pp_neg | output | ROWS | Per-row negation flag, +1 owed at the row's LSB |

## Verification
Several internal faults show up at the ports. A wrong window alignment or a missing sign repeat changes a row's digit. An error in the shared 3Y adder corrupts every row whose digit has magnitude 3. A wrong inversion or flag leaves the reassembled sum off by a multiple of 8^j. Each of these faults is visible in the rows and in the weighted sum one cycle after the operands are strobed. A lost clock enable shows up as rows that change, or `pp_valid` that stays high, in the first idle cycle.

// File: rtl/booth_r8_pkg.sv
package booth_r8_pkg;

  // Signed radix-8 digit: sign flag plus magnitude 0..4
  typedef struct packed {
    logic       neg;
    logic [2:0] mag;
  } r8_digit_t;

  localparam logic [2:0] MAG_ZERO  = 3'd0;
  localparam logic [2:0] MAG_ONE   = 3'd1;
  localparam logic [2:0] MAG_TWO   = 3'd2;
  localparam logic [2:0] MAG_THREE = 3'd3;
  localparam logic [2:0] MAG_FOUR  = 3'd4;

endpackage

// File: rtl/booth_r8_recode.sv
module booth_r8_recode
  import booth_r8_pkg::*;
#(
  parameter int N    = 16,
  parameter int ROWS = (N + 2) / 3
) (
  input  logic [N-1:0]               mplier,
  output r8_digit_t [ROWS-1:0]       digits
);

  localparam int EXTW = 3 * ROWS + 1;

  // ext[0] is the implicit zero below the LSB; ext[k+1] is multiplier bit k,
  // sign-repeated above bit N-1.
  logic [EXTW-1:0] ext;

  always_comb begin
    for (int k = 0; k < EXTW; k++) begin
      if (k == 0)          ext[k] = 1'b0;
      else if (k - 1 < N)  ext[k] = mplier[k-1];
      else                 ext[k] = mplier[N-1];
    end
  end

  for (genvar j = 0; j < ROWS; j++) begin : g_win
    logic [3:0] win;
    logic [2:0] pos_part;

    assign win      = ext[3*j +: 4];
    // 2*b(i+1) + b(i) + b(i-1), range 0..4
    assign pos_part = {win[2], 1'b0} + {2'b00, win[1]} + {2'b00, win[0]};

    always_comb begin
      if (win[3]) begin
        digits[j].neg = (pos_part != MAG_FOUR);
        digits[j].mag = MAG_FOUR - pos_part;
      end else begin
        digits[j].neg = 1'b0;
        digits[j].mag = pos_part;
      end
    end
  end

endmodule

// File: rtl/booth_r8_triple.sv
module booth_r8_triple #(
  parameter int W = 19
) (
  input  logic [W-1:0] y1,
  output logic [W-1:0] y3
);

  // Single shared adder: Y + 2Y
  assign y3 = y1 + {y1[W-2:0], 1'b0};

endmodule

// File: rtl/booth_r8_rowsel.sv
module booth_r8_rowsel
  import booth_r8_pkg::*;
#(
  parameter int W = 19
) (
  input  r8_digit_t    digit,
  input  logic [W-1:0] y1,
  input  logic [W-1:0] y3,
  output logic [W-1:0] row
);

  logic [W-1:0] pick;

  always_comb begin
    case (digit.mag)
      MAG_ONE:   pick = y1;
      MAG_TWO:   pick = {y1[W-2:0], 1'b0};
      MAG_THREE: pick = y3;
      MAG_FOUR:  pick = {y1[W-3:0], 2'b00};
      default:   pick = '0;
    endcase
  end

  // Inversion only; the +1 travels on the negation flag
  assign row = pick ^ {W{digit.neg}};

endmodule

// File: rtl/booth_r8_ppgen.sv
module booth_r8_ppgen
  import booth_r8_pkg::*;
#(
  parameter int N = 16,
  localparam int ROWS = (N + 2) / 3,
  localparam int W    = N + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [N-1:0]        mplier,
  input  logic [N-1:0]        mcand,
  output logic                pp_valid,
  output logic [ROWS*W-1:0]   pp_rows,
  output logic [ROWS-1:0]     pp_neg
);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // Datapath
  r8_digit_t [ROWS-1:0] digits;
  logic [W-1:0]         y1, y3;
  logic [ROWS*W-1:0]    rows_c;
  logic [ROWS-1:0]      neg_c;

  assign y1 = {{(W-N){mcand[N-1]}}, mcand};

  booth_r8_recode #(.N(N), .ROWS(ROWS)) u_recode (
    .mplier (mplier),
    .digits (digits)
  );

  booth_r8_triple #(.W(W)) u_triple (
    .y1 (y1),
    .y3 (y3)
  );

  for (genvar j = 0; j < ROWS; j++) begin : g_row
    booth_r8_rowsel #(.W(W)) u_sel (
      .digit (digits[j]),
      .y1    (y1),
      .y3    (y3),
      .row   (rows_c[j*W +: W])
    );
    assign neg_c[j] = digits[j].neg;
  end

  // Next state with explicit clock enable
  logic [ROWS*W-1:0] rows_d, rows_q;
  logic [ROWS-1:0]   neg_d, neg_q;
  logic              vld_d, vld_q;

  always_comb begin
    rows_d = in_valid ? rows_c : rows_q;
    neg_d  = in_valid ? neg_c  : neg_q;
    vld_d  = in_valid;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rows_q <= '0;
      neg_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      rows_q <= rows_d;
      neg_q  <= neg_d;
      vld_q  <= vld_d;
    end
  end

  assign pp_rows  = rows_q;
  assign pp_neg   = neg_q;
  assign pp_valid = vld_q;

  // R7
  load_valid_chk: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> pp_valid);

  // R7
  idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> !pp_valid);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> ($stable(pp_rows) && $stable(pp_neg)));

  // R3
  zero_mplier_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && mplier == '0) |=> (pp_rows == '0 && pp_neg == '0));

  for (genvar j = 0; j < ROWS; j++) begin : g_zchk
    // R2
    zero_mcand_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (in_valid && mcand == '0) |=> (pp_rows[j*W +: W] == {W{pp_neg[j]}}));
  end

endmodule

// File: tb/tb_booth_r8_ppgen.sv
module tb_booth_r8_ppgen;

  localparam int N    = 16;
  localparam int ROWS = (N + 2) / 3;
  localparam int W    = N + 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [N-1:0]      mplier, mcand;
  logic              pp_valid;
  logic [ROWS*W-1:0] pp_rows;
  logic [ROWS-1:0]   pp_neg;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 0;
  bit  seen [9];

  always #2.5 clk = ~clk;

  booth_r8_ppgen #(.N(N)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .mplier   (mplier),
    .mcand    (mcand),
    .pp_valid (pp_valid),
    .pp_rows  (pp_rows),
    .pp_neg   (pp_neg)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int mbit(input logic [N-1:0] a, input int k);
    if (k < 0)  return 0;
    if (k >= N) return int'(a[N-1]);
    return int'(a[k]);
  endfunction

  // Strobe one operand pair, then check rows, flags, valid and the sum
  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b);
    longint sy, acc, prod;
    logic [ROWS-1:0] exp_neg;
    @(negedge clk);
    mplier = a; mcand = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(pp_valid == 1'b1, "R7 valid after load", longint'(pp_valid), 1);
    sy  = longint'($signed(b));
    acc = 0;
    for (int j = 0; j < ROWS; j++) begin
      int d, mag;
      longint m;
      logic [W-1:0] exp_row;
      logic signed [W-1:0] got;
      string req;
      d = -4*mbit(a, 3*j+2) + 2*mbit(a, 3*j+1) + mbit(a, 3*j) + mbit(a, 3*j-1);
      seen[d+4] = 1'b1;
      mag = (d < 0) ? -d : d;
      m = longint'(mag) * sy;
      exp_row = (d < 0) ? W'(~m) : W'(m);
      exp_neg[j] = (d < 0);
      req = (mag == 3) ? "R4 row via 3Y" : ((mag == 2 || mag == 4) ? "R5 shifted row" : "R2 row");
      got = pp_rows[j*W +: W];
      chk(got == exp_row, req, longint'(got), longint'(exp_row));
      acc += (longint'(got) + longint'(pp_neg[j])) <<< (3*j);
    end
    chk(pp_neg == exp_neg, "R3 negation flags", longint'(pp_neg), longint'(exp_neg));
    prod = longint'($signed(a)) * sy;
    chk(acc == prod, "R6 weighted sum", acc, prod);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; in_valid = 1'b0; mplier = '0; mcand = '0;
    repeat (3) @(negedge clk);
    chk(pp_rows == '0, "R9 rows in reset", longint'(pp_rows), 0);
    chk(pp_neg == '0, "R9 flags in reset", longint'(pp_neg), 0);
    chk(pp_valid == 1'b0, "R9 valid in reset", longint'(pp_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(pp_valid == 1'b0, "R9 valid idle after release", longint'(pp_valid), 0);
  endtask

  task automatic test_corners();
    logic [N-1:0] ms [10];
    logic [N-1:0] cs [6];
    ms = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000,
           16'h5555, 16'hAAAA, 16'h3333, 16'h6DB6, 16'h9249};
    cs = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h1234};
    foreach (ms[i]) foreach (cs[k]) run_op(ms[i], cs[k]);
  endtask

  task automatic test_random();
    for (int i = 0; i < 300; i++) run_op(N'($urandom), N'($urandom));
  endtask

  task automatic test_digit_cover();
    // All nine digit values of R1 must have occurred across the runs
    for (int d = 0; d < 9; d++)
      chk(seen[d], "R1 digit coverage", longint'(seen[d]), 1);
  endtask

  task automatic test_hold();
    logic [ROWS*W-1:0] rows_ref;
    logic [ROWS-1:0]   neg_ref;
    run_op(16'hB5C3, 16'h8001);
    rows_ref = pp_rows; neg_ref = pp_neg;
    for (int i = 0; i < 3; i++) begin
      mplier = N'($urandom); mcand = N'($urandom);
      @(negedge clk);
      chk(pp_rows == rows_ref, "R8 rows hold", longint'(pp_rows[63:0]), longint'(rows_ref[63:0]));
      chk(pp_neg == neg_ref, "R8 flags hold", longint'(pp_neg), longint'(neg_ref));
      chk(pp_valid == 1'b0, "R7 valid drops when idle", longint'(pp_valid), 0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    test_reset();
    test_corners();
    test_random();
    test_hold();
    test_digit_cover();
    finish_run();
  end

  initial begin
    #500000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule